// File: doc/BRIEF.md
# Message Descriptor Stack Writer

This block keeps a chronological record of every bus message a remote terminal handles. For each message it writes a four-word descriptor into a ring of words in a shared synchronous RAM. The ring starts at a fixed base address and holds a fixed number of words set by a parameter. The descriptor is opened when the message starts, with the status word marked as in progress. When the message ends, the descriptor is closed: the status word is rewritten as complete, with the error flags added.

The message sequencer gives the block a start event with the bus channel, the time tag and the received command word. It gives an end event with the illegal-command flag, the error flags, the data block pointer and an optional mode-code data word. The block drives a single RAM write port and holds the ring pointer. After each closed descriptor it advances the pointer by one descriptor. It raises single-cycle interrupt pulses when the pointer reaches the middle of the ring and when it wraps to the start. The host may reload the pointer while no message is open.

Top module: `desc_stack_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `stack_ptr` is 0 and `ram_we`, `irq_half` and `irq_full` are low.
- R2: `msg_start` is sampled at a clock edge while the block is idle. Over the next three cycles the block writes three words, each to `BASE_ADDR + stack_ptr + k`. First comes the status word (k=0): bit 15 = 1 (in progress), bit 14 = 0, bit 13 = `bus_chan`, all other bits 0. Next comes `time_tag` (k=1), then `cmd_word` (k=3). The channel, time tag and command word are the values present at the start edge.
- R3: `msg_end` is sampled while a descriptor is open and its opening writes are finished. The block then writes the third word (k=2) in the next cycle. In the cycle after that it rewrites the status word (k=0) as: bit 15 = 0, bit 14 = 1 (complete), bit 13 = channel, bit 12 = `illegal_cmd`, bits 3:0 = `msg_err`, and bits 11:4 = 0. The flags are the values present at the end edge.
- R4: The third word is `mode_data` when both `is_mode_code` and `mc_store_en` are high at the end edge. Otherwise it is `data_ptr`.
- R5: The pointer advances at the edge that ends the closing status write, so the new value is visible in the cycle after that write. It advances by 4 modulo `STACK_WORDS`, and it changes at no other time except a host load.
- R6: When an advance moves an armed pointer to the mid-point or above (`STACK_WORDS/2`), `irq_half` pulses for exactly one cycle, in the same cycle the new pointer appears. The mid-point tracking is then disarmed. A wrap to 0 arms it again.
- R7: When an advance wraps the pointer to 0, `irq_full` pulses for exactly one cycle, in the same cycle the new pointer appears.
- R8: A pulse appears only if its enable (`half_irq_en` for `irq_half`, `full_irq_en` for `irq_full`) is high at the advancing edge. A disabled pulse still lets the pointer and the tracking update.
- R9: `ptr_load` is sampled while idle. It sets `stack_ptr` to `ptr_load_val` with bits 1:0 cleared, and the new value is visible the next cycle. The load arms mid-point tracking if the loaded value is below the mid-point and disarms it otherwise. A load while a message is in progress is ignored.
- R10: `msg_start` is ignored while a message is in progress, or when it arrives in the same cycle as an accepted load. `msg_end` is ignored unless a descriptor is open and its opening writes are finished. An ignored event causes no RAM write.
- R11: `ram_we` is high only in the five descriptor write cycles of a message, and every write address lies in `[BASE_ADDR, BASE_ADDR + STACK_WORDS)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Message start event |
| msg_end | input | 1 | Message end event |
| bus_chan | input | 1 | Channel the message arrived on, sampled at start |
| illegal_cmd | input | 1 | Illegal command flag, sampled at end |
| msg_err | input | 4 | Message error flags, sampled at end |
| time_tag | input | 16 | Current time tag, sampled at start |
| cmd_word | input | 16 | Received command word, sampled at start |
| data_ptr | input | 16 | Data block pointer, sampled at end |
| mode_data | input | 16 | Mode-code data word, sampled at end |
| is_mode_code | input | 1 | Message is a mode-code command, sampled at end |
| mc_store_en | input | 1 | Option: store mode-code data in place of the pointer |
| half_irq_en | input | 1 | Enable for the mid-point pulse |
| full_irq_en | input | 1 | Enable for the wrap pulse |
| ptr_load | input | 1 | Host pointer load request |
| ptr_load_val | input | PTR_W | Pointer value to load |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| stack_ptr | output | PTR_W | Current ring pointer (word offset) |
| irq_half | output | 1 | Mid-point rollover pulse |
| irq_full | output | 1 | Full rollover pulse |

## Verification
The opening writes fall in the first, second and third cycles after the start edge. The idle check comes in the fourth cycle. The third word and the closing status come in the first and second cycles after the end edge. The new pointer and any interrupt pulse appear in the third cycle after the end edge, and the fourth cycle must show both pulses low again. The bench drives inputs on falling edges and compares outputs on the falling edge of exactly those cycles. It also scrambles the sampled inputs right after each event edge, which proves they were captured at that edge. A reference pointer and an armed flag, updated arithmetically per message over several wraps and two loads, give the expected pointer and pulses.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    localparam int WORD_W     = 16;
    localparam int ERR_W      = 4;
    localparam int DESC_WORDS = 4;

    // word offsets inside one descriptor
    localparam logic [1:0] OFS_STAT = 2'd0;
    localparam logic [1:0] OFS_TIME = 2'd1;
    localparam logic [1:0] OFS_DPTR = 2'd2;
    localparam logic [1:0] OFS_CMD  = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN_STAT,
        PH_OPEN_TIME,
        PH_OPEN_CMD,
        PH_ACTIVE,
        PH_CLOSE_THIRD,
        PH_CLOSE_STAT
    } phase_e;

    typedef struct packed {
        logic             in_prog;
        logic             done;
        logic             chan;
        logic             illegal;
        logic [7:0]       spare;
        logic [ERR_W-1:0] err;
    } bsw_t;

    typedef struct packed {
        logic              chan;
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] cmd;
    } open_t;

    typedef struct packed {
        logic              illegal;
        logic [ERR_W-1:0]  err;
        logic [WORD_W-1:0] third;
    } close_t;

    function automatic bsw_t make_bsw(input logic closing, input logic chan,
                                      input logic illegal, input logic [ERR_W-1:0] err);
        bsw_t s;
        s.in_prog = ~closing;
        s.done    = closing;
        s.chan    = chan;
        s.illegal = closing & illegal;
        s.spare   = '0;
        s.err     = closing ? err : '0;
        return s;
    endfunction

endpackage

// File: rtl/dsw_seq.sv
module dsw_seq
    import dsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   msg_start,
    input  logic   msg_end,
    input  logic   ptr_load,
    output phase_e phase,
    output logic   take_open,
    output logic   take_close,
    output logic   load_ok,
    output logic   advance
);

    phase_e phase_q, phase_d;

    assign load_ok    = (phase_q == PH_IDLE) && ptr_load;
    assign take_open  = (phase_q == PH_IDLE) && msg_start && !ptr_load;
    assign take_close = (phase_q == PH_ACTIVE) && msg_end;
    assign advance    = (phase_q == PH_CLOSE_STAT);
    assign phase      = phase_q;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:        if (take_open) phase_d = PH_OPEN_STAT;
            PH_OPEN_STAT:   phase_d = PH_OPEN_TIME;
            PH_OPEN_TIME:   phase_d = PH_OPEN_CMD;
            PH_OPEN_CMD:    phase_d = PH_ACTIVE;
            PH_ACTIVE:      if (take_close) phase_d = PH_CLOSE_THIRD;
            PH_CLOSE_THIRD: phase_d = PH_CLOSE_STAT;
            PH_CLOSE_STAT:  phase_d = PH_IDLE;
            default:        phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

endmodule

// File: rtl/dsw_ptr.sv
module dsw_ptr
    import dsw_pkg::*;
#(
    parameter int STACK_WORDS = 32,
    localparam int PTR_W = $clog2(STACK_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_ok,
    input  logic [PTR_W-1:0] load_val,
    input  logic             advance,
    input  logic             half_en,
    input  logic             full_en,
    output logic [PTR_W-1:0] ptr,
    output logic             irq_half,
    output logic             irq_full
);

    localparam logic [PTR_W-1:0] MID  = PTR_W'(STACK_WORDS / 2);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_WORDS);

    logic [PTR_W-1:0] ptr_q, nxt, aligned;
    logic             armed_q;
    logic             wrap, mid_hit;

    assign nxt     = ptr_q + STEP;
    assign aligned = {load_val[PTR_W-1:2], 2'b00};
    assign wrap    = (nxt == '0);
    assign mid_hit = armed_q && (nxt >= MID);
    assign ptr     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            armed_q  <= 1'b1;
            irq_half <= 1'b0;
            irq_full <= 1'b0;
        end else begin
            irq_half <= 1'b0;
            irq_full <= 1'b0;
            if (load_ok) begin
                ptr_q   <= aligned;
                armed_q <= (aligned < MID);
            end else if (advance) begin
                ptr_q    <= nxt;
                irq_half <= mid_hit && half_en;
                irq_full <= wrap && full_en;
                if (wrap)         armed_q <= 1'b1;
                else if (mid_hit) armed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dsw_fmt.sv
module dsw_fmt
    import dsw_pkg::*;
#(
    parameter int          STACK_WORDS = 32,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 256,
    localparam int PTR_W = $clog2(STACK_WORDS)
) (
    input  phase_e            phase,
    input  logic [PTR_W-1:0]  ptr,
    input  open_t             op,
    input  close_t            cl,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);

    logic [1:0] ofs;

    always_comb begin
        we    = 1'b1;
        ofs   = OFS_STAT;
        wdata = '0;
        unique case (phase)
            PH_OPEN_STAT: begin
                ofs   = OFS_STAT;
                wdata = make_bsw(1'b0, op.chan, 1'b0, '0);
            end
            PH_OPEN_TIME: begin
                ofs   = OFS_TIME;
                wdata = op.tag;
            end
            PH_OPEN_CMD: begin
                ofs   = OFS_CMD;
                wdata = op.cmd;
            end
            PH_CLOSE_THIRD: begin
                ofs   = OFS_DPTR;
                wdata = cl.third;
            end
            PH_CLOSE_STAT: begin
                ofs   = OFS_STAT;
                wdata = make_bsw(1'b1, op.chan, cl.illegal, cl.err);
            end
            default: we = 1'b0;
        endcase
    end

    assign addr = ADDR_W'(BASE_ADDR) + ADDR_W'(ptr) + ADDR_W'(ofs);

endmodule

// File: rtl/desc_stack_writer.sv
module desc_stack_writer
    import dsw_pkg::*;
#(
    parameter int          STACK_WORDS = 32,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 256,
    localparam int PTR_W = $clog2(STACK_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_start,
    input  logic              msg_end,
    input  logic              bus_chan,
    input  logic              illegal_cmd,
    input  logic [ERR_W-1:0]  msg_err,
    input  logic [WORD_W-1:0] time_tag,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0] data_ptr,
    input  logic [WORD_W-1:0] mode_data,
    input  logic              is_mode_code,
    input  logic              mc_store_en,
    input  logic              half_irq_en,
    input  logic              full_irq_en,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_load_val,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  stack_ptr,
    output logic              irq_half,
    output logic              irq_full
);

    phase_e phase;
    logic   take_open, take_close, load_ok, advance;
    open_t  open_q;
    close_t close_q;

    dsw_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .msg_start  (msg_start),
        .msg_end    (msg_end),
        .ptr_load   (ptr_load),
        .phase      (phase),
        .take_open  (take_open),
        .take_close (take_close),
        .load_ok    (load_ok),
        .advance    (advance)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= '0;
            close_q <= '0;
        end else begin
            if (take_open) begin
                open_q.chan <= bus_chan;
                open_q.tag  <= time_tag;
                open_q.cmd  <= cmd_word;
            end
            if (take_close) begin
                close_q.illegal <= illegal_cmd;
                close_q.err     <= msg_err;
                close_q.third   <= (is_mode_code && mc_store_en) ? mode_data : data_ptr;
            end
        end
    end

    dsw_ptr #(.STACK_WORDS(STACK_WORDS)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load_ok  (load_ok),
        .load_val (ptr_load_val),
        .advance  (advance),
        .half_en  (half_irq_en),
        .full_en  (full_irq_en),
        .ptr      (stack_ptr),
        .irq_half (irq_half),
        .irq_full (irq_full)
    );

    dsw_fmt #(
        .STACK_WORDS (STACK_WORDS),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR)
    ) u_fmt (
        .phase (phase),
        .ptr   (stack_ptr),
        .op    (open_q),
        .cl    (close_q),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata)
    );

endmodule

// File: rtl/dsw_chk.sv
module dsw_chk #(
    parameter int          STACK_WORDS = 32,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 256,
    localparam int PTR_W = $clog2(STACK_WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              ptr_load,
    input logic              half_irq_en,
    input logic              full_irq_en,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [PTR_W-1:0]  stack_ptr,
    input logic              irq_half,
    input logic              irq_full
);

    localparam logic [PTR_W-1:0]  MID     = PTR_W'(STACK_WORDS / 2);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + STACK_WORDS);

    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr >= LO_ADDR && ram_addr < HI_ADDR)); // R11

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (stack_ptr != $past(stack_ptr) && !$past(ptr_load))
            |-> (stack_ptr == $past(stack_ptr) + PTR_W'(4))); // R5

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (stack_ptr != $past(stack_ptr) && !$past(ptr_load)) |-> $past(ram_we)); // R5

    AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_full |-> (stack_ptr == '0)); // R7

    AST_HALF_AT_MID: assert property (@(posedge clk) disable iff (rst)
        irq_half |-> (stack_ptr == MID)); // R6

    AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_half |=> !irq_half); // R6

    AST_FULL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_full |=> !irq_full); // R7

    AST_HALF_GATED: assert property (@(posedge clk) disable iff (rst)
        !$past(half_irq_en) |-> !irq_half); // R8

    AST_FULL_GATED: assert property (@(posedge clk) disable iff (rst)
        !$past(full_irq_en) |-> !irq_full); // R8

endmodule

bind desc_stack_writer dsw_chk #(
    .STACK_WORDS (STACK_WORDS),
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR)
) u_chk (.*);

// File: tb/desc_stack_writer_tb.sv
module desc_stack_writer_tb;

    localparam int SW    = 32;
    localparam int MID   = 16;
    localparam int BASE  = 256;
    localparam int PTR_W = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, msg_start, msg_end, bus_chan, illegal_cmd;
    logic [3:0]  msg_err;
    logic [15:0] time_tag, cmd_word, data_ptr, mode_data;
    logic is_mode_code, mc_store_en, half_irq_en, full_irq_en, ptr_load;
    logic [PTR_W-1:0] ptr_load_val;
    logic ram_we;
    logic [15:0] ram_addr, ram_wdata;
    logic [PTR_W-1:0] stack_ptr;
    logic irq_half, irq_full;

    desc_stack_writer u_dut (.*);

    int checks = 0;
    int failures = 0;
    int exp_ptr = 0;
    bit armed = 1'b1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_write(input string req, input int ofs, input logic [15:0] data);
        chk(req, "ram_we", 32'(ram_we), 32'd1);
        chk(req, "ram_addr", 32'(ram_addr), 32'(BASE + exp_ptr + ofs));
        chk(req, "ram_wdata", 32'(ram_wdata), 32'(data));
    endtask

    task automatic run_msg(input logic ch, input logic ill, input logic [3:0] er,
                           input logic [15:0] tt, input logic [15:0] cw,
                           input logic [15:0] dp, input logic [15:0] md,
                           input logic mc, input logic opt,
                           input logic he, input logic fe);
        int nxt;
        bit eh, ef;
        @(negedge clk);
        msg_start = 1'b1; bus_chan = ch; time_tag = tt; cmd_word = cw;
        @(negedge clk);
        msg_start = 1'b0; bus_chan = ~ch; time_tag = ~tt; cmd_word = ~cw;
        chk_write("R2", 0, {1'b1, 1'b0, ch, 13'd0});
        @(negedge clk);
        chk_write("R2", 1, tt);
        @(negedge clk);
        chk_write("R2", 3, cw);
        @(negedge clk);
        chk("R11", "idle we while open", 32'(ram_we), 32'd0);
        // stray start and load while the message is open
        msg_start = 1'b1; ptr_load = 1'b1; ptr_load_val = 5'h1c;
        @(negedge clk);
        msg_start = 1'b0; ptr_load = 1'b0;
        chk("R10", "start while open", 32'(ram_we), 32'd0);
        chk("R9", "load while open", 32'(stack_ptr), 32'(exp_ptr));
        msg_end = 1'b1; illegal_cmd = ill; msg_err = er; data_ptr = dp;
        mode_data = md; is_mode_code = mc; mc_store_en = opt;
        half_irq_en = he; full_irq_en = fe;
        @(negedge clk);
        msg_end = 1'b0; illegal_cmd = ~ill; msg_err = ~er; data_ptr = ~dp;
        mode_data = ~md; is_mode_code = ~mc; mc_store_en = ~opt;
        chk_write("R4", 2, (mc && opt) ? md : dp);
        @(negedge clk);
        chk_write("R3", 0, {1'b0, 1'b1, ch, ill, 8'd0, er});
        chk("R5", "ptr before advance", 32'(stack_ptr), 32'(exp_ptr));
        nxt = (exp_ptr + 4) % SW;
        ef  = (nxt == 0);
        eh  = armed && (nxt >= MID);
        if (ef)      armed = 1'b1;
        else if (eh) armed = 1'b0;
        @(negedge clk);
        chk("R5", "ptr advanced", 32'(stack_ptr), 32'(nxt));
        chk("R6", "irq_half", 32'(irq_half), 32'(eh && he));
        chk("R7", "irq_full", 32'(irq_full), 32'(ef && fe));
        chk("R11", "we after close", 32'(ram_we), 32'd0);
        @(negedge clk);
        chk("R6", "half pulse width", 32'(irq_half), 32'd0);
        chk("R7", "full pulse width", 32'(irq_full), 32'd0);
        exp_ptr = nxt;
    endtask

    task automatic host_load(input logic [PTR_W-1:0] v, input logic with_start);
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = v; msg_start = with_start;
        @(negedge clk);
        ptr_load = 1'b0; msg_start = 1'b0;
        exp_ptr = int'(v) & ~3;
        armed   = (exp_ptr < MID);
        chk("R9", "loaded ptr", 32'(stack_ptr), 32'(exp_ptr));
        chk("R10", "start with load", 32'(ram_we), 32'd0);
        @(negedge clk);
        chk("R10", "no open after load", 32'(ram_we), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; msg_start = 0; msg_end = 0; bus_chan = 0; illegal_cmd = 0;
        msg_err = 0; time_tag = 0; cmd_word = 0; data_ptr = 0; mode_data = 0;
        is_mode_code = 0; mc_store_en = 0; half_irq_en = 1; full_irq_en = 1;
        ptr_load = 0; ptr_load_val = 0;
        repeat (3) @(negedge clk);
        chk("R1", "ptr in reset", 32'(stack_ptr), 32'd0);
        chk("R1", "we in reset", 32'(ram_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ptr after reset", 32'(stack_ptr), 32'd0);
        chk("R1", "we after reset", 32'(ram_we), 32'd0);
        chk("R1", "irqs after reset", 32'({irq_half, irq_full}), 32'd0);

        // end event while idle
        msg_end = 1'b1;
        @(negedge clk);
        msg_end = 1'b0;
        chk("R10", "end while idle", 32'(ram_we), 32'd0);
        @(negedge clk);
        chk("R10", "end while idle later", 32'(ram_we), 32'd0);
        chk("R10", "ptr unchanged", 32'(stack_ptr), 32'd0);

        // sweep over two and a half wraps
        for (int i = 0; i < 20; i++) begin
            run_msg(i[0], i[1], 4'(i * 5 + 3),
                    16'(16'h1000 + i * 37), 16'(16'h8421 ^ (i * 91)),
                    16'(16'h0400 + i * 32), 16'(16'hA000 + i),
                    i[1], i[2], (i % 5) != 3, i != 15);
        end

        // load into upper half: no mid pulse until after a wrap
        host_load(5'h13, 1'b1);
        for (int i = 0; i < 6; i++)
            run_msg(1'b1, 1'b0, 4'(i), 16'(i), 16'(i + 7), 16'(i + 9), 16'(i + 11),
                    1'b1, 1'b1, 1'b1, 1'b1);

        // load into lower half re-arms tracking
        host_load(5'h06, 1'b0);
        for (int i = 0; i < 3; i++)
            run_msg(1'b0, 1'b1, 4'hF, 16'hFFFF, 16'h0000, 16'h5555, 16'hAAAA,
                    1'b1, 1'b0, 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule